// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over many clock cycles and returns the 64-bit product as two 32-bit words. It holds one 32-bit adder. The partial product and the multiplier share a single 64-bit register that shifts right. The multiplicand register is loaded at the start and does not change after that. On every step the block looks at the lowest bit of the shared register. If that bit is 1, it adds the multiplicand into the upper half. The adder carry becomes the new top bit as the register shifts right by one place.

In signed mode the block first replaces each negative operand with its magnitude. It then multiplies the two magnitudes and negates the 64-bit result when the operand signs differ. In unsigned mode the operands go in unchanged. A caller pulses `start` while the block is idle and then waits for the one-cycle `done` strobe. The result words stay where they are until the next operation finishes.

Top module: `shift_add_mult`

## Requirements
- R1: With `signedMode` low, the operands are read as unsigned numbers and `{resHi,resLo}` equals their exact 64-bit product.
- R2: With `signedMode` high, the operands are read as two's complement numbers and `{resHi,resLo}` equals their exact signed 64-bit product. This includes the most negative operand value.
- R3: `resHi` carries product bits 63..32 and `resLo` carries product bits 31..0.
- R4: A `start` sampled high while `busy` is low is accepted. `busy` is high in the cycle after the accepting edge.
- R5: `done` rises after the 34th rising edge, counting the accepting edge as the first: one load, 32 add/shift steps and one sign-fix edge.
- R6: `done` is high for exactly one cycle, and `busy` is low while `done` is high.
- R7: A `start` sampled while `busy` is high is ignored. The running operation keeps its operands, its latency and its result.
- R8: `resHi` and `resLo` change only at the edge that raises `done`. Between operations they hold the last product.
- R9: After reset, `busy`, `done`, `resHi` and `resLo` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiply when idle |
| signedMode | input | 1 | 1: two's complement operands, 0: unsigned |
| opA | input | 32 | Multiplicand operand |
| opB | input | 32 | Multiplier operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle strobe, result words updated |
| resHi | output | 32 | Upper half of the product |
| resLo | output | 32 | Lower half of the product |

## Verification
The checker captures the operands and the mode only on an accepted `start`. It therefore takes for granted that `opA`, `opB` and `signedMode` are valid in that cycle, and nothing more. The bench drives each operation with a single-cycle `start` pulse from idle, and it sets operands at that same moment. It also raises `start` in the middle of an operation, with different operands, to show that the block ignores the request. Operands come from a seeded generator, and fixed corner values are mixed in: zero, one, all ones, the most negative value and the most positive value.

// File: rtl/shift_add_mult_pkg.sv
package shift_add_mult_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture magnitudes, seed shared register
    logic step;    // one conditional add and right shift
    logic finish;  // apply sign, publish result words
  } mulCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mulState_t;
endpackage

// File: rtl/mul_datapath.sv
module mul_datapath
  import shift_add_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulCtrl_t         ctrl,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] resHi,
  output logic [WIDTH-1:0] resLo
);
  localparam int PW = 2 * WIDTH;

  logic             aNeg, bNeg;
  logic [WIDTH-1:0] aMag, bMag;
  logic [WIDTH-1:0] mcand;
  logic [PW-1:0]    prodReg;
  logic             negFlag;
  logic [WIDTH:0]   sum;
  logic [PW-1:0]    fixed;

  // magnitude conversion; the most negative value maps to itself,
  // which is its correct unsigned magnitude
  always_comb begin
    aNeg = signedMode & opA[WIDTH-1];
    bNeg = signedMode & opB[WIDTH-1];
    aMag = aNeg ? (~opA + WIDTH'(1)) : opA;
    bMag = bNeg ? (~opB + WIDTH'(1)) : opB;
  end

  // the single adder: upper half plus gated multiplicand, carry kept
  always_comb begin
    sum = {1'b0, prodReg[PW-1:WIDTH]} + {1'b0, (prodReg[0] ? mcand : '0)};
  end

  always_comb begin
    fixed = negFlag ? (~prodReg + PW'(1)) : prodReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand   <= '0;
      prodReg <= '0;
      negFlag <= 1'b0;
      resHi   <= '0;
      resLo   <= '0;
    end else begin
      if (ctrl.load) begin
        mcand   <= aMag;
        prodReg <= {{WIDTH{1'b0}}, bMag};
        negFlag <= aNeg ^ bNeg;
      end else if (ctrl.step) begin
        prodReg <= {sum, prodReg[WIDTH-1:1]};
      end
      if (ctrl.finish) begin
        resHi <= fixed[PW-1:WIDTH];
        resLo <= fixed[WIDTH-1:0];
      end
    end
  end
endmodule

// File: rtl/mul_control.sv
module mul_control
  import shift_add_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output mulCtrl_t ctrl,
  output logic     busy,
  output logic     done
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  mulState_t        state;
  logic [CNT_W-1:0] stepCnt;
  logic             doneReg;

  always_comb begin
    ctrl.load   = (state == ST_IDLE) && start;
    ctrl.step   = (state == ST_RUN);
    ctrl.finish = (state == ST_FIX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= (state == ST_FIX);
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: begin
          stepCnt <= stepCnt + CNT_W'(1);
          if (stepCnt == LAST_STEP) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
  import shift_add_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] resHi,
  output logic [WIDTH-1:0] resLo
);
  mulCtrl_t ctrl;

  mul_control #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .signedMode (signedMode),
    .opA        (opA),
    .opB        (opB),
    .resHi      (resHi),
    .resLo      (resLo)
  );
endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             signedMode,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] resHi,
  input logic [WIDTH-1:0] resLo
);
  localparam int PW    = 2 * WIDTH;
  localparam int BC_W  = $clog2(WIDTH + 2) + 1;

  logic [PW-1:0]   expProd;
  logic [BC_W-1:0] busyCnt;
  logic [PW-1:0]   extA, extB;

  always_comb begin
    extA = signedMode ? {{WIDTH{opA[WIDTH-1]}}, opA} : {{WIDTH{1'b0}}, opA};
    extB = signedMode ? {{WIDTH{opB[WIDTH-1]}}, opB} : {{WIDTH{1'b0}}, opB};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expProd <= '0;
      busyCnt <= '0;
    end else if (start && !busy) begin
      expProd <= extA * extB;
      busyCnt <= '0;
    end else if (busy) begin
      busyCnt <= busyCnt + BC_W'(1);
    end
  end

  // R1, R2, R3: published words form the exact product
  p_product_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ({resHi, resLo} == expProd));
  p_busy_on_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == BC_W'(WIDTH + 1)));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({resHi, resLo}));
endmodule

bind shift_add_mult shift_add_mult_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/shift_add_mult_tb.sv
module shift_add_mult_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         signedMode = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic         busy, done;
  logic [W-1:0] resHi, resLo;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shift_add_mult u_dut (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .opA(opA), .opB(opB), .busy(busy), .done(done),
    .resHi(resHi), .resLo(resLo)
  );

  function automatic logic [63:0] refProd(logic [31:0] a, logic [31:0] b, logic sgn);
    logic [63:0] ea, eb;
    ea = sgn ? {{32{a[31]}}, a} : {32'b0, a};
    eb = sgn ? {{32{b[31]}}, b} : {32'b0, b};
    return ea * eb;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation; optional mid-run start with other operands (R7)
  task automatic runOp(logic [31:0] a, logic [31:0] b, logic sgn, bit poke, string req);
    logic [63:0] exp;
    int cnt;
    exp = refProd(a, b, sgn);
    @(negedge clk);
    opA = a; opB = b; signedMode = sgn; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R4 busy after start", {63'b0, busy}, 64'd1);
    cnt = 0;
    while (!done && cnt < 100) begin
      if (poke && cnt == 10) begin
        opA = ~a; opB = b + 32'd7; signedMode = ~sgn; start = 1'b1;
      end
      @(posedge clk);
      cnt++;
      @(negedge clk);
      start = 1'b0;
      opA = '0; opB = '0;
    end
    check(cnt == W + 1, "R5 latency", 64'(cnt), 64'(W + 1));
    check({resHi, resLo} == exp, req, {resHi, resLo}, exp);
    check(!busy, "R6 busy low with done", {63'b0, busy}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    check(!done, "R6 done single cycle", {63'b0, done}, 64'd0);
  endtask

  initial begin
    logic [63:0] held;
    logic [31:0] ra, rb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R9 reset flags", {62'b0, busy, done}, 64'd0);
    check({resHi, resLo} == 0, "R9 reset result", {resHi, resLo}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(32'd1000, 32'd1001, 1'b0, 0, "R1 small unsigned");
    runOp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, "R1 all ones unsigned");
    runOp(32'h0, 32'hDEAD_BEEF, 1'b0, 0, "R1 zero");
    runOp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 0, "R2 minus one squared");
    runOp(32'h8000_0000, 32'h8000_0000, 1'b1, 0, "R2 most negative squared");
    runOp(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 0, "R2 min times max");
    runOp(32'hFFFF_FFF9, 32'd2, 1'b1, 0, "R2 negative times positive");
    runOp(32'd1, 32'h8000_0000, 1'b1, 0, "R2 one times most negative");
    runOp(32'h0001_0000, 32'h0001_0000, 1'b0, 0, "R3 word split");
    check(resHi == 32'd1 && resLo == 32'd0, "R3 hi word", {resHi, resLo}, 64'h1_0000_0000);
    runOp(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1, "R7 ignored start");

    held = {resHi, resLo};
    repeat (12) @(negedge clk);
    check({resHi, resLo} == held, "R8 hold after done", {resHi, resLo}, held);

    for (int i = 0; i < 150; i++) begin
      ra = $urandom();
      rb = $urandom();
      if (i % 5 == 0) ra = {ra[31], 31'h0} | (ra & 32'hF);
      runOp(ra, rb, i[0], 0, i[0] ? "R2 random signed" : "R1 random unsigned");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule